// File: doc/BRIEF.md
# Low-Power Card Detection Sequencer

This block schedules card detection for a contactless reader front end while it spends most of its time powered down. Once started, it waits in standby for a programmed number of millisecond ticks, then switches the RF field on for a short ping. At the last microsecond tick of the ping it takes the AGC measurement and compares it with a stored reference. If the measurement falls outside a window of reference minus threshold to reference plus threshold, it raises a sticky wake interrupt and stops. Otherwise it goes back to standby and repeats the cycle.

The reference comes from one of two calibration schemes. In automatic mode, a calibration ping with a configured gear is run when detection starts, and its result becomes the reference. In self-calibration mode, the host reads a reference configuration word, which runs a calibration ping and returns the gear and the measurement. The host then writes that word back with the same measured value. Detection starts only after this read-then-write sequence has completed.

Top module: `lpcd_seq`

## Requirements
- R1: After reset, `rf_en`, `wake_irq`, `err` and `ref_done` are all 0.
- R2: Every ping holds `rf_en` high for exactly 62 + 8·`cfg_fon` microsecond ticks (for example 62, 70 or 190 for `cfg_fon` of 0, 1 or 16). `rf_en` drops in the cycle after the last tick.
- R3: Between two pings, `rf_en` stays low for `cfg_standby` millisecond ticks, with 0 treated as 1. No ping starts while no millisecond tick arrives.
- R4: A detection ping sets `wake_irq` when the sample is above reference + `cfg_thresh` or below reference − `cfg_thresh`. A sample equal to either bound does not wake.
- R5: The window bounds saturate at 0 and 1023. A reference near either end never wraps into a wake.
- R6: With `cfg_mode` = 2'b00, `start` runs a calibration ping first, using gear `cfg_auto_gear` on `gear_sel`. Its sample becomes the reference for detection.
- R7: A detection ping that ends inside the window returns to standby, and another ping follows.
- R8: `wake_irq` stays 1 until `clr` is pulsed. After a wake, no further ping occurs until a new `start`.
- R9: The decision uses the sample present at the last microsecond tick of the ping. Values seen earlier in the same ping do not count.
- R10: In the idle state, a `ref_rd` before any valid handshake runs a ping with gear `dpc_gear`. The ping is then followed by a one-cycle `ref_done`, and `ref_rdata` holds the gear in bits 13:10, the sample in bits 9:0 and zeros in bits 15:14. After a valid handshake, `ref_rd` returns the stored word in the next cycle without a ping.
- R11: A `ref_wr` runs a ping whose gear is taken from bits 13:10 of `ref_wdata`. The ping ends with a one-cycle `ref_done`.
- R12: `start` in self-calibration mode (`cfg_mode` = 2'b01) is accepted only if the last write carried, in bits 9:0, the value returned by the read just before it. Otherwise, and for reserved modes 2'b10 and 2'b11, no ping starts and `err` is set. `err` is cleared by `clr` or by an accepted start. An accepted self-mode start uses the written gear and value for detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond tick |
| ms_tick | input | 1 | One-cycle millisecond tick |
| agc_valid | input | 1 | AGC sample strobe |
| agc_value | input | 10 | AGC measurement |
| cfg_mode | input | 2 | 00 automatic, 01 self-calibration, others reserved |
| cfg_auto_gear | input | 4 | Gear for automatic-mode pings |
| cfg_thresh | input | 10 | Half-width of the quiet window |
| cfg_fon | input | 8 | Extra ping length in 8-tick units |
| cfg_standby | input | 16 | Standby length in millisecond ticks |
| dpc_gear | input | 4 | Gear currently chosen by power control, used by read calibration |
| start | input | 1 | Start detection (idle only) |
| clr | input | 1 | Clear wake interrupt and error |
| ref_rd | input | 1 | Read request for the reference word |
| ref_wr | input | 1 | Write request for the reference word |
| ref_wdata | input | 16 | Written reference word |
| rf_en | output | 1 | RF field enable |
| gear_sel | output | 4 | Gear of the current or last ping |
| wake_irq | output | 1 | Sticky wake interrupt |
| err | output | 1 | Start rejected |
| ref_rdata | output | 16 | Read reference word |
| ref_done | output | 1 | One-cycle completion of a read or write |

## Verification
The assertions check four properties on every cycle. The ping counter never passes the programmed length. The field is off during standby and in the cycle where a wake is reported. The interrupt holds until cleared, and a rejected start raises the error without lighting the field. A sample at the reference never lies outside the window, and the lower bound never passes the upper one. The bench scenarios alone can show the behaviours that depend on counts and on sequences across several operations. These are the exact ping and standby lengths, the window bounds and saturation, and the use of only the last-tick sample. They also include the gear and reference in each mode, and the read-then-write gating of self-calibration.

// File: rtl/lpcd_pkg.sv
package lpcd_pkg;
    localparam int AGC_W    = 10;
    localparam int GEAR_W   = 4;
    localparam int REG_W    = 16;
    localparam int GEAR_LSB = 10;

    typedef logic [AGC_W-1:0]  agc_t;
    typedef logic [GEAR_W-1:0] gear_t;
    typedef logic [REG_W-1:0]  word_t;

    typedef enum logic [1:0] {
        MODE_AUTO = 2'b00,
        MODE_SELF = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL,
        ST_SBY,
        ST_DET,
        ST_RDP,
        ST_WRP
    } state_e;

    typedef struct packed {
        gear_t gear;
        agc_t  agc;
    } ref_cfg_t;

    function automatic word_t pack_ref(ref_cfg_t r);
        return {{(REG_W-GEAR_W-AGC_W){1'b0}}, r.gear, r.agc};
    endfunction

    function automatic ref_cfg_t unpack_ref(word_t w);
        ref_cfg_t r;
        r.gear = w[GEAR_LSB +: GEAR_W];
        r.agc  = w[AGC_W-1:0];
        return r;
    endfunction

    function automatic agc_t sat_add(agc_t a, agc_t b);
        logic [AGC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[AGC_W] ? '1 : s[AGC_W-1:0];
    endfunction

    function automatic agc_t sat_sub(agc_t a, agc_t b);
        return (a < b) ? '0 : (a - b);
    endfunction
endpackage

// File: rtl/lpcd_ping_timer.sv
module lpcd_ping_timer #(
    parameter int FON_W   = 8,
    parameter int BASE_US = 62,
    parameter int STEP_US = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [FON_W-1:0] fon,
    input  logic             us_tick,
    output logic             run,
    output logic             last
);
    localparam int MAX_US = BASE_US + STEP_US * ((1 << FON_W) - 1);
    localparam int LEN_W  = $clog2(MAX_US + 1);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             run_q;

    assign run  = run_q;
    assign last = run_q && us_tick && (cnt_q == len_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            len_q <= '0;
        end else if (go) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            len_q <= LEN_W'(BASE_US) + LEN_W'(STEP_US) * LEN_W'(fon);
        end else if (run_q && us_tick) begin
            if (last) run_q <= 1'b0;
            else      cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assert_ping_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < len_q));
endmodule

// File: rtl/lpcd_standby_timer.sv
module lpcd_standby_timer #(
    parameter int SBY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [SBY_W-1:0] period,
    input  logic             ms_tick,
    output logic             run,
    output logic             done
);
    logic [SBY_W-1:0] cnt_q;
    logic [SBY_W-1:0] lim_q;
    logic             run_q;

    assign run  = run_q;
    assign done = run_q && ms_tick && (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (go) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            lim_q <= (period == '0) ? '0 : period - SBY_W'(1);
        end else if (run_q && ms_tick) begin
            if (done) run_q <= 1'b0;
            else      cnt_q <= cnt_q + SBY_W'(1);
        end
    end
endmodule

// File: rtl/lpcd_window_cmp.sv
module lpcd_window_cmp
    import lpcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  agc_t ref_val,
    input  agc_t thresh,
    input  agc_t sample,
    output logic outside
);
    agc_t hi;
    agc_t lo;

    always_comb begin
        hi      = sat_add(ref_val, thresh);
        lo      = sat_sub(ref_val, thresh);
        outside = (sample > hi) || (sample < lo);
    end

    assert_center_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (sample == ref_val) |-> !outside);

    assert_window_order_R5: assert property (@(posedge clk) disable iff (rst)
        lo <= hi);
endmodule

// File: rtl/lpcd_seq.sv
module lpcd_seq
    import lpcd_pkg::*;
#(
    parameter int FON_W   = 8,
    parameter int SBY_W   = 16,
    parameter int BASE_US = 62,
    parameter int STEP_US = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               us_tick,
    input  logic               ms_tick,
    input  logic               agc_valid,
    input  logic [AGC_W-1:0]   agc_value,
    input  logic [1:0]         cfg_mode,
    input  logic [GEAR_W-1:0]  cfg_auto_gear,
    input  logic [AGC_W-1:0]   cfg_thresh,
    input  logic [FON_W-1:0]   cfg_fon,
    input  logic [SBY_W-1:0]   cfg_standby,
    input  logic [GEAR_W-1:0]  dpc_gear,
    input  logic               start,
    input  logic               clr,
    input  logic               ref_rd,
    input  logic               ref_wr,
    input  logic [REG_W-1:0]   ref_wdata,
    output logic               rf_en,
    output logic [GEAR_W-1:0]  gear_sel,
    output logic               wake_irq,
    output logic               err,
    output logic [REG_W-1:0]   ref_rdata,
    output logic               ref_done
);
    state_e   st_q, st_d;
    mode_e    mode;
    agc_t     held_q, eff_smp, det_ref_q, rd_val_q;
    gear_t    det_gear_q, gear_q, ping_gear;
    ref_cfg_t ref_reg_q;
    word_t    rdata_q;
    logic     hs_ok_q, rd_done_q, done_q, irq_q, err_q;
    logic     ping_go, sby_go, ping_last, ping_run, sby_done, sby_run, outside;
    logic     start_auto, start_self, start_rej, rd_fast, wr_acc;

    assign mode    = mode_e'(cfg_mode);
    assign eff_smp = agc_valid ? agc_value : held_q;

    lpcd_ping_timer #(.FON_W(FON_W), .BASE_US(BASE_US), .STEP_US(STEP_US)) u_ping (
        .clk(clk), .rst(rst), .go(ping_go), .fon(cfg_fon), .us_tick(us_tick),
        .run(ping_run), .last(ping_last)
    );

    lpcd_standby_timer #(.SBY_W(SBY_W)) u_sby (
        .clk(clk), .rst(rst), .go(sby_go), .period(cfg_standby), .ms_tick(ms_tick),
        .run(sby_run), .done(sby_done)
    );

    lpcd_window_cmp u_cmp (
        .clk(clk), .rst(rst), .ref_val(det_ref_q), .thresh(cfg_thresh),
        .sample(eff_smp), .outside(outside)
    );

    always_comb begin
        st_d       = st_q;
        ping_go    = 1'b0;
        sby_go     = 1'b0;
        ping_gear  = gear_q;
        start_auto = 1'b0;
        start_self = 1'b0;
        start_rej  = 1'b0;
        rd_fast    = 1'b0;
        wr_acc     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (mode == MODE_AUTO) begin
                        start_auto = 1'b1;
                        ping_go    = 1'b1;
                        ping_gear  = cfg_auto_gear;
                        st_d       = ST_CAL;
                    end else if (mode == MODE_SELF && hs_ok_q) begin
                        start_self = 1'b1;
                        sby_go     = 1'b1;
                        st_d       = ST_SBY;
                    end else begin
                        start_rej  = 1'b1;
                    end
                end else if (ref_rd) begin
                    if (hs_ok_q) begin
                        rd_fast   = 1'b1;
                    end else begin
                        ping_go   = 1'b1;
                        ping_gear = dpc_gear;
                        st_d      = ST_RDP;
                    end
                end else if (ref_wr) begin
                    wr_acc    = 1'b1;
                    ping_go   = 1'b1;
                    ping_gear = ref_wdata[GEAR_LSB +: GEAR_W];
                    st_d      = ST_WRP;
                end
            end
            ST_CAL: if (ping_last) begin
                sby_go = 1'b1;
                st_d   = ST_SBY;
            end
            ST_SBY: if (sby_done) begin
                ping_go   = 1'b1;
                ping_gear = det_gear_q;
                st_d      = ST_DET;
            end
            ST_DET: if (ping_last) begin
                if (outside) begin
                    st_d = ST_IDLE;
                end else begin
                    sby_go = 1'b1;
                    st_d   = ST_SBY;
                end
            end
            ST_RDP, ST_WRP: if (ping_last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            held_q     <= '0;
            det_ref_q  <= '0;
            det_gear_q <= '0;
            gear_q     <= '0;
            rd_val_q   <= '0;
            ref_reg_q  <= '0;
            rdata_q    <= '0;
            hs_ok_q    <= 1'b0;
            rd_done_q  <= 1'b0;
            done_q     <= 1'b0;
            irq_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= 1'b0;
            if (ping_go) gear_q <= ping_gear;
            if (ping_run && agc_valid) held_q <= agc_value;

            if (start_auto) det_gear_q <= cfg_auto_gear;
            if (start_self) begin
                det_gear_q <= ref_reg_q.gear;
                det_ref_q  <= ref_reg_q.agc;
            end
            if (st_q == ST_CAL && ping_last) det_ref_q <= eff_smp;

            if (st_q == ST_RDP && ping_last) begin
                rd_val_q  <= eff_smp;
                rd_done_q <= 1'b1;
                rdata_q   <= pack_ref('{gear: gear_q, agc: eff_smp});
                done_q    <= 1'b1;
            end
            if (rd_fast) begin
                rdata_q <= pack_ref(ref_reg_q);
                done_q  <= 1'b1;
            end
            if (wr_acc) begin
                ref_reg_q <= unpack_ref(ref_wdata);
                hs_ok_q   <= rd_done_q && (ref_wdata[AGC_W-1:0] == rd_val_q);
                rd_done_q <= 1'b0;
            end
            if (st_q == ST_WRP && ping_last) done_q <= 1'b1;

            if (start_rej)                            err_q <= 1'b1;
            else if (clr || start_auto || start_self) err_q <= 1'b0;

            if (st_q == ST_DET && ping_last && outside) irq_q <= 1'b1;
            else if (clr)                               irq_q <= 1'b0;
        end
    end

    assign rf_en     = ping_run;
    assign gear_sel  = gear_q;
    assign wake_irq  = irq_q;
    assign err       = err_q;
    assign ref_rdata = rdata_q;
    assign ref_done  = done_q;

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (wake_irq && !clr) |=> wake_irq);

    assert_rf_off_at_wake_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_irq) |-> !rf_en);

    assert_standby_dark_R3: assert property (@(posedge clk) disable iff (rst)
        sby_run |-> !rf_en);

    assert_reject_R12: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start && mode != MODE_AUTO && !hs_ok_q) |=> (err && !rf_en));
endmodule

// File: tb/lpcd_seq_test.sv
`timescale 1ns/1ps
module lpcd_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b1, ms_tick = 1'b1, agc_valid = 1'b1;
    logic [9:0]  agc_value = '0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [3:0]  cfg_auto_gear = 4'd3;
    logic [9:0]  cfg_thresh = 10'd20;
    logic [7:0]  cfg_fon = 8'd0;
    logic [15:0] cfg_standby = 16'd3;
    logic [3:0]  dpc_gear = 4'd9;
    logic        start = 1'b0, clr = 1'b0, ref_rd = 1'b0, ref_wr = 1'b0;
    logic [15:0] ref_wdata = '0;
    logic        rf_en, wake_irq, err, ref_done;
    logic [3:0]  gear_sel;
    logic [15:0] ref_rdata;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [9:0] early_val = '0, late_val = '0;
    int late_at = 100000;
    int rfc = 0;

    always #2.5 clk = ~clk;

    lpcd_seq uut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .ms_tick(ms_tick),
        .agc_valid(agc_valid), .agc_value(agc_value), .cfg_mode(cfg_mode),
        .cfg_auto_gear(cfg_auto_gear), .cfg_thresh(cfg_thresh), .cfg_fon(cfg_fon),
        .cfg_standby(cfg_standby), .dpc_gear(dpc_gear), .start(start), .clr(clr),
        .ref_rd(ref_rd), .ref_wr(ref_wr), .ref_wdata(ref_wdata), .rf_en(rf_en),
        .gear_sel(gear_sel), .wake_irq(wake_irq), .err(err),
        .ref_rdata(ref_rdata), .ref_done(ref_done)
    );

    // AGC model: value depends on the index of the current RF-on cycle
    always @(negedge clk) begin
        if (rf_en) rfc = rfc + 1;
        else       rfc = 0;
        agc_value = (rfc >= late_at) ? late_val : early_val;
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog expired: actual %0d cycles, expected below 150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
                $finish;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; clr = 1'b0; ref_rd = 1'b0; ref_wr = 1'b0;
        ref_wdata = '0; us_tick = 1'b1; ms_tick = 1'b1;
        early_val = '0; late_val = '0; late_at = 100000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic measure_ping(output int w, output int g);
        int guard = 0;
        while (!rf_en && guard < 5000) begin guard++; @(negedge clk); end
        w = 0; g = int'(gear_sel);
        while (rf_en) begin w++; g = int'(gear_sel); @(negedge clk); end
    endtask

    task automatic measure_gap(output int gp);
        gp = 0;
        while (!rf_en && gp < 5000) begin gp++; @(negedge clk); end
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1 rf_en", int'(rf_en), 0);
        chk("R1 wake_irq", int'(wake_irq), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 ref_done", int'(ref_done), 0);
    endtask

    task automatic test_ping_len(input int fon, input int exp_len);
        int w, g, gp;
        do_reset();
        cfg_mode = 2'b00; cfg_thresh = 10'd1023; cfg_auto_gear = 4'd3;
        cfg_fon = 8'(fon); cfg_standby = 16'd5;
        pulse_start();
        measure_ping(w, g);
        chk("R2 calibration ping length", w, exp_len);
        chk("R6 calibration gear", g, 3);
        measure_gap(gp);
        chk("R3 standby length", gp, 5);
        measure_ping(w, g);
        chk("R2 detection ping length", w, exp_len);
        chk("R7 no wake, cycle repeats", int'(wake_irq), 0);
        measure_gap(gp);
        chk("R7 second standby", gp, 5);
    endtask

    task automatic test_standby_edges();
        int w, g, gp, lit;
        do_reset();
        cfg_mode = 2'b00; cfg_thresh = 10'd1023; cfg_fon = 8'd0; cfg_standby = 16'd0;
        pulse_start();
        measure_ping(w, g);
        measure_gap(gp);
        chk("R3 zero standby counts as one", gp, 1);
        do_reset();
        cfg_standby = 16'd2;
        pulse_start();
        ms_tick = 1'b0;
        measure_ping(w, g);
        lit = 0;
        repeat (400) begin @(negedge clk); if (rf_en) lit++; end
        chk("R3 no ping without ms ticks", lit, 0);
        ms_tick = 1'b1;
        measure_gap(gp);
        chk("R3 standby resumes with ticks", gp, 2);
    endtask

    task automatic run_det(input int rv, input int th, input int smp,
                           input int lat, input int lval, output int wake, output int gap);
        int w, g;
        do_reset();
        cfg_mode = 2'b00; cfg_thresh = 10'(th); cfg_fon = 8'd0; cfg_standby = 16'd3;
        early_val = 10'(rv);
        pulse_start();
        measure_ping(w, g);
        early_val = 10'(smp); late_val = 10'(lval); late_at = lat;
        measure_ping(w, g);
        wake = int'(wake_irq);
        late_at = 100000;
        if (wake == 0) measure_gap(gap);
        else gap = -1;
    endtask

    task automatic test_window();
        int wk, gp;
        run_det(500, 20, 520, 100000, 0, wk, gp);
        chk("R4 upper bound equal no wake", wk, 0);
        chk("R7 back to standby after quiet ping", gp, 3);
        run_det(500, 20, 521, 100000, 0, wk, gp);
        chk("R4 above upper bound wakes", wk, 1);
        run_det(500, 20, 480, 100000, 0, wk, gp);
        chk("R4 lower bound equal no wake", wk, 0);
        run_det(500, 20, 479, 100000, 0, wk, gp);
        chk("R4 below lower bound wakes", wk, 1);
        run_det(1010, 50, 1023, 100000, 0, wk, gp);
        chk("R5 high saturation no wake", wk, 0);
        run_det(10, 50, 0, 100000, 0, wk, gp);
        chk("R5 low saturation no wake", wk, 0);
        run_det(1000, 10, 1023, 100000, 0, wk, gp);
        chk("R5 near top still wakes past bound", wk, 1);
    endtask

    task automatic test_last_tick();
        int wk, gp;
        run_det(500, 20, 900, 62, 500, wk, gp);
        chk("R9 late in-window sample governs", wk, 0);
        run_det(500, 20, 500, 62, 900, wk, gp);
        chk("R9 late out-of-window sample wakes", wk, 1);
    endtask

    task automatic test_sticky();
        int wk, gp, lit;
        run_det(500, 20, 600, 100000, 0, wk, gp);
        chk("R8 wake raised", wk, 1);
        lit = 0;
        repeat (300) begin @(negedge clk); if (rf_en) lit++; end
        chk("R8 idle after wake", lit, 0);
        chk("R8 irq held", int'(wake_irq), 1);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R8 irq cleared by clr", int'(wake_irq), 0);
    endtask

    task automatic test_selfcal();
        int w, g, gp, lit;
        do_reset();
        cfg_mode = 2'b01; cfg_fon = 8'd1; cfg_thresh = 10'd10; cfg_standby = 16'd4;
        dpc_gear = 4'd9; early_val = 10'd345;
        pulse_start();
        chk("R12 start before handshake rejected", int'(err), 1);
        lit = 0;
        repeat (50) begin @(negedge clk); if (rf_en) lit++; end
        chk("R12 no ping after reject", lit, 0);
        ref_rd = 1'b1; @(negedge clk); ref_rd = 1'b0;
        measure_ping(w, g);
        chk("R10 read ping length", w, 70);
        chk("R10 read ping uses dpc gear", g, 9);
        chk("R10 read done pulse", int'(ref_done), 1);
        chk("R10 read word", int'(ref_rdata), (9 << 10) | 345);
        ref_wdata = 16'((5 << 10) | 345);
        ref_wr = 1'b1; @(negedge clk); ref_wr = 1'b0;
        measure_ping(w, g);
        chk("R11 write ping gear from bits 13:10", g, 5);
        chk("R11 write done pulse", int'(ref_done), 1);
        ref_rd = 1'b1; @(negedge clk); ref_rd = 1'b0;
        chk("R10 read after handshake done at once", int'(ref_done), 1);
        chk("R10 read after handshake no ping", int'(rf_en), 0);
        chk("R10 stored word returned", int'(ref_rdata), (5 << 10) | 345);
        early_val = 10'd400;
        pulse_start();
        chk("R12 accepted start clears err", int'(err), 0);
        measure_gap(gp);
        chk("R3 self-mode standby", gp, 4);
        measure_ping(w, g);
        chk("R12 detection uses written gear", g, 5);
        chk("R12 detection uses written reference", int'(wake_irq), 1);
    endtask

    task automatic test_bad_handshake();
        int w, g;
        do_reset();
        cfg_mode = 2'b01; cfg_fon = 8'd0; cfg_standby = 16'd3; dpc_gear = 4'd2;
        early_val = 10'd345;
        ref_rd = 1'b1; @(negedge clk); ref_rd = 1'b0;
        measure_ping(w, g);
        ref_wdata = 16'hC000 | 16'((10 << 10) | 300);
        ref_wr = 1'b1; @(negedge clk); ref_wr = 1'b0;
        measure_ping(w, g);
        chk("R11 gear taken from bits 13:10 only", g, 10);
        pulse_start();
        chk("R12 mismatched write rejects start", int'(err), 1);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R12 clr clears err", int'(err), 0);
        cfg_mode = 2'b10;
        pulse_start();
        chk("R12 reserved mode rejected", int'(err), 1);
        chk("R12 reserved mode no ping", int'(rf_en), 0);
    endtask

    initial begin
        test_reset();
        test_ping_len(0, 62);
        test_ping_len(1, 70);
        test_ping_len(16, 190);
        test_standby_edges();
        test_window();
        test_last_tick();
        test_sticky();
        test_selfcal();
        test_bad_handshake();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule